// File: doc/BRIEF.md
# Small 16-bit Multicycle Processor Core

The core is a multicycle 16-bit processor. It has eight general registers, a program counter, an instruction register and a three-bit condition code (negative, zero, positive). It runs seven instructions: register or immediate add, register or immediate and, conditional branch, PC-relative address load, register jump, base-plus-offset memory load, and a vectored trap.

The core reaches a synchronous word-addressed memory through an enable, a read/write select, an address, a returned data word and a ready flag. A request is one cycle with the enable high. The core then waits in a wait state for as many cycles as the memory needs, and it moves on in the cycle in which ready is high. The program counter, the condition code and the register-file write port are brought out as observation outputs, so a system can follow execution.

Each instruction takes a fetch cycle, a fetch-wait phase and a decode cycle. Branch, jump and unused opcodes finish in decode. Arithmetic and address-load instructions add one execute cycle. Memory load and trap add a request cycle and a wait phase.

Top module: `mc16_core`

## Requirements
- R1: While reset is held, and until the two-stage release of reset completes, mem_en is 0, pc_o is 0, nzp_o is 3'b010 and rf_we_o is 0. All registers hold 0. The first request after reset reads address 0.
- R2: A fetch is one cycle with mem_en=1 and mem_addr=PC, and PC increments by one at the end of that cycle. The core then waits with mem_en=0 until mem_ready=1, latches mem_rdata as the instruction, and decodes it in the next cycle. mem_en is never high in two consecutive cycles.
- R3: Opcodes sit in bits 15:12. ADD (4'b0001) and AND (4'b0101) write DR (bits 11:9) with SR1 (bits 8:6) combined with a second operand. When bit 5 is 0, that operand is register bits 2:0. When bit 5 is 1, it is bits 4:0 sign-extended. The write occurs in the cycle after decode.
- R4: ADD, AND, LEA and LDR set exactly one flag from the value written: N when bit 15 is 1, Z when the value is zero, P otherwise. nzp_o packs the flags as {N,Z,P}. TRAP, BR and JMP leave the flags unchanged.
- R5: BR (4'b0000) is taken when (bits 11:9 & {N,Z,P}) is not zero, with bits 11:9 being the n, z and p mask. A taken branch sets PC to the incremented PC plus bits 8:0 sign-extended, in the decode cycle. The condition is evaluated only in decode. The all-zero word changes nothing but PC.
- R6: LEA (4'b1110) writes DR with the incremented PC plus bits 8:0 sign-extended, without a memory access.
- R7: JMP (4'b1100) sets PC to the register named by bits 8:6, in the decode cycle.
- R8: LDR (4'b0110) makes one read at base register (bits 8:6) plus bits 5:0 sign-extended, and writes the returned word to DR when ready arrives. Every access has mem_rw=0 (read).
- R9: TRAP (4'b1111) writes R7 with the incremented PC in the decode cycle. It then reads address {8'h00, bits 7:0} and loads the returned word into PC.
- R10: Any other opcode does nothing beyond the PC increment of its fetch.
- R11: mem_rdata is ignored in every cycle in which mem_ready is 0, whatever the length of the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en | output | 1 | Memory request strobe, one cycle per access |
| mem_rw | output | 1 | Access direction, always 0 (read) |
| mem_addr | output | 16 | Word address of the request |
| mem_rdata | input | 16 | Returned data word, valid with mem_ready |
| mem_ready | input | 1 | Response valid for the outstanding request |
| pc_o | output | 16 | Current program counter |
| nzp_o | output | 3 | Condition code {N,Z,P} |
| rf_we_o | output | 1 | Register file write this cycle |
| rf_waddr_o | output | 3 | Register written |
| rf_wdata_o | output | 16 | Value written |

## Verification
A single program exercises the instructions under the following patterns:
- register and immediate operands;
- negative immediates and offsets, including an address that crosses below zero;
- an and whose result is zero;
- a branch whose mask misses the flags, the all-zero word, and a taken branch that skips two instructions;
- a load from a negative base address, a trap into a vector at page zero and a return by register jump;
- an unused opcode.

The memory answers after a latency that cycles through one, two and three cycles, and it drives a junk word whenever ready is low. This separates a core that waits correctly from one that assumes a fixed latency or samples data early. A cycle-level behavioural model is compared on every clock against the request, the program counter, the flags and the register write port. Final register values, worked out by hand, cover errors that the model and the core might share.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W  = 16;
  localparam int REG_N   = 8;
  localparam int REG_AW  = $clog2(REG_N);
  localparam int OP_W    = 4;
  localparam int TVEC_W  = 8;

  localparam logic [OP_W-1:0] OP_BR   = 4'b0000;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_AND  = 4'b0101;
  localparam logic [OP_W-1:0] OP_LDR  = 4'b0110;
  localparam logic [OP_W-1:0] OP_JMP  = 4'b1100;
  localparam logic [OP_W-1:0] OP_LEA  = 4'b1110;
  localparam logic [OP_W-1:0] OP_TRAP = 4'b1111;

  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(REG_N - 1);

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_EXEC,
    ST_LDRD, ST_LDWT, ST_TRAD, ST_TRWT
  } state_e;
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (we && (waddr == AW'(i))) regs_q[i] <= wdata;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/mc16_exu.sv
module mc16_exu import mc16_pkg::*; #(
  parameter int W = WORD_W,
  localparam int IMM_W = 5,
  localparam int LOFF_W = 6,
  localparam int BOFF_W = 9
) (
  input  logic [W-1:0] ir,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] arith_res,
  output logic [W-1:0] ldr_addr,
  output logic [W-1:0] br_target
);
  logic [W-1:0] imm_x, loff_x, boff_x, opnd2;

  assign imm_x  = {{(W-IMM_W){ir[IMM_W-1]}},   ir[IMM_W-1:0]};
  assign loff_x = {{(W-LOFF_W){ir[LOFF_W-1]}}, ir[LOFF_W-1:0]};
  assign boff_x = {{(W-BOFF_W){ir[BOFF_W-1]}}, ir[BOFF_W-1:0]};

  assign opnd2     = ir[IMM_W] ? imm_x : opb;
  assign br_target = pc + boff_x;
  assign ldr_addr  = opa + loff_x;

  always_comb begin
    unique case (ir[W-1 -: OP_W])
      OP_AND:  arith_res = opa & opnd2;
      OP_LEA:  arith_res = br_target;
      default: arith_res = opa + opnd2;
    endcase
  end
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl import mc16_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic            mem_ready,
  output state_e          state,
  output logic            req
);
  state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_FETCH:  state_d = ST_FWAIT;
      ST_FWAIT:  if (mem_ready) state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (op)
          OP_ADD, OP_AND, OP_LEA: state_d = ST_EXEC;
          OP_LDR:                 state_d = ST_LDRD;
          OP_TRAP:                state_d = ST_TRAD;
          default:                state_d = ST_FETCH;
        endcase
      end
      ST_EXEC:   state_d = ST_FETCH;
      ST_LDRD:   state_d = ST_LDWT;
      ST_LDWT:   if (mem_ready) state_d = ST_FETCH;
      ST_TRAD:   state_d = ST_TRWT;
      ST_TRWT:   if (mem_ready) state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_d;
  end

  assign req = (state == ST_FETCH) || (state == ST_LDRD) || (state == ST_TRAD);

  AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R2
endmodule

// File: rtl/mc16_core.sv
module mc16_core import mc16_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_en,
  output logic              mem_rw,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] pc_o,
  output logic [2:0]        nzp_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [WORD_W-1:0] rf_wdata_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WORD_W-1:0] pc_q, pc_d, ir_q, ir_d;
  logic [2:0]        nzp_q, nzp_d;
  logic              pc_en, ir_en, nzp_en;
  logic [OP_W-1:0]   op;
  logic [WORD_W-1:0] src_a, src_b, arith_res, ldr_addr, br_target;
  logic              rf_we, ben, req;
  logic [REG_AW-1:0] rf_waddr;
  logic [WORD_W-1:0] rf_wdata;
  state_e            state;

  assign op  = ir_q[WORD_W-1 -: OP_W];
  assign ben = |(ir_q[11:9] & nzp_q);

  mc16_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .op(op), .mem_ready(mem_ready),
    .state(state), .req(req)
  );

  mc16_regfile #(.W(WORD_W), .N(REG_N)) i_rf (
    .clk(clk), .rst_n(rst_int_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(ir_q[8:6]), .raddr_b(ir_q[2:0]), .rdata_a(src_a), .rdata_b(src_b)
  );

  mc16_exu #(.W(WORD_W)) i_exu (
    .ir(ir_q), .pc(pc_q), .opa(src_a), .opb(src_b),
    .arith_res(arith_res), .ldr_addr(ldr_addr), .br_target(br_target)
  );

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    unique case (state)
      ST_FETCH:  begin pc_en = 1'b1; pc_d = pc_q + 1'b1; end
      ST_DECODE: begin
        if (op == OP_BR && ben) begin pc_en = 1'b1; pc_d = br_target; end
        if (op == OP_JMP)       begin pc_en = 1'b1; pc_d = src_a;     end
      end
      ST_TRWT:   if (mem_ready) begin pc_en = 1'b1; pc_d = mem_rdata; end
      default:   ;
    endcase
  end

  assign ir_en = (state == ST_FWAIT) && mem_ready;
  assign ir_d  = mem_rdata;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ir_q[11:9];
    rf_wdata = arith_res;
    unique case (state)
      ST_DECODE: if (op == OP_TRAP) begin
        rf_we = 1'b1; rf_waddr = LINK_REG; rf_wdata = pc_q;
      end
      ST_EXEC:   rf_we = 1'b1;
      ST_LDWT:   if (mem_ready) begin rf_we = 1'b1; rf_wdata = mem_rdata; end
      default:   ;
    endcase
  end

  assign nzp_en = rf_we && (state != ST_DECODE);
  assign nzp_d  = rf_wdata[WORD_W-1] ? 3'b100 :
                  (rf_wdata == '0)   ? 3'b010 : 3'b001;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      nzp_q <= 3'b010;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (nzp_en) nzp_q <= nzp_d;
    end
  end

  always_comb begin
    unique case (state)
      ST_LDRD: mem_addr = ldr_addr;
      ST_TRAD: mem_addr = {{(WORD_W-TVEC_W){1'b0}}, ir_q[TVEC_W-1:0]};
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_en     = req && rst_int_n;
  assign mem_rw     = 1'b0;
  assign pc_o       = pc_q;
  assign nzp_o      = nzp_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = rf_waddr;
  assign rf_wdata_o = rf_wdata;

  AST_NZP_ONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(nzp_q) == 1); // R4
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_FETCH) |=> ((pc_q - $past(pc_q)) == WORD_W'(1))); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_FWAIT && !mem_ready) |=> $stable(ir_q)); // R11
  AST_TRAP_PAGE0: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_en && state == ST_TRAD) |-> (mem_addr[WORD_W-1:TVEC_W] == '0)); // R9
endmodule

// File: tb/test_mc16_core.sv
module test_mc16_core;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 420;

  logic        clk, rst_n;
  logic        mem_en, mem_rw, mem_ready;
  logic [15:0] mem_addr, mem_rdata, pc_o, rf_wdata_o;
  logic [2:0]  nzp_o, rf_waddr_o;
  logic        rf_we_o;

  int n_chk, n_bad;
  bit finished;

  mc16_core i_mc16_core (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_o(pc_o), .nzp_o(nzp_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // memory: latency cycles through 1,2,3; junk data while not ready
  logic [15:0] mem [64];
  logic [5:0]  pend_addr;
  bit          busy;
  int          cnt, req_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_rdata <= 16'hDEAD; busy <= 0; cnt <= 0; req_n <= 0;
    end else begin
      mem_ready <= 1'b0;
      mem_rdata <= 16'hDEAD;
      if (mem_en) begin
        if (req_n % 3 == 0) begin
          mem_ready <= 1'b1; mem_rdata <= mem[mem_addr[5:0]];
        end else begin
          busy <= 1; cnt <= (req_n % 3) - 1; pend_addr <= mem_addr[5:0];
        end
        req_n <= req_n + 1;
      end else if (busy) begin
        if (cnt == 0) begin
          mem_ready <= 1'b1; mem_rdata <= mem[pend_addr]; busy <= 0;
        end else cnt <= cnt - 1;
      end
    end
  end

  // behavioural reference
  logic [15:0] m_r [8];
  logic [15:0] m_pc, m_ir, seen_w [8];
  logic [2:0]  m_nzp;
  int          ph, r6_writes;
  bit          m_s1, m_s2;

  function automatic logic [15:0] sx(input logic [15:0] raw, input int bits);
    int v;
    v = int'(raw) & ((1 << bits) - 1);
    if (v >= (1 << (bits - 1))) v = v - (1 << bits);
    return 16'(v);
  endfunction

  function automatic logic [2:0] flags_of(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0001, 4'b0101: return "R3";
      4'b0000: return "R5";
      4'b1110: return "R6";
      4'b1100: return "R7";
      4'b0110: return "R8";
      4'b1111: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] calc(input logic [15:0] ir, input logic [15:0] pc);
    logic [15:0] b;
    b = ir[5] ? sx(ir, 5) : m_r[ir[2:0]];
    case (ir[15:12])
      4'b0101: return m_r[ir[8:6]] & b;
      4'b1110: return pc + sx(ir, 9);
      default: return m_r[ir[8:6]] + b;
    endcase
  endfunction

  always @(negedge clk) begin
    logic        e_en, e_we;
    logic [15:0] e_addr, e_wd;
    logic [2:0]  e_wa;
    string       tg;
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    if (!m_s2) begin
      ph = 0; m_pc = 0; m_ir = 0; m_nzp = 3'b010;
      for (int i = 0; i < 8; i++) m_r[i] = 16'h0;
    end
    e_en = 0; e_we = 0; e_addr = 0; e_wd = 0; e_wa = m_ir[11:9];
    if (m_s2) begin
      case (ph)
        0: begin e_en = 1; e_addr = m_pc; end
        2: if (m_ir[15:12] == 4'b1111) begin e_we = 1; e_wa = 3'd7; e_wd = m_pc; end
        3: begin e_we = 1; e_wd = calc(m_ir, m_pc); end
        4: begin e_en = 1; e_addr = m_r[m_ir[8:6]] + sx(m_ir, 6); end
        5: if (mem_ready) begin e_we = 1; e_wd = mem_rdata; end
        6: begin e_en = 1; e_addr = {8'h00, m_ir[7:0]}; end
        default: ;
      endcase
    end
    if (!m_s2) tg = "R1";
    else if (ph <= 1) tg = (ph == 1 && !mem_ready) ? "R11" : "R2";
    else tg = tag_of(m_ir[15:12]);
    chk(tg, "mem_en", 16'(mem_en), 16'(e_en));
    chk("R8", "mem_rw", 16'(mem_rw), 16'h0);
    if (e_en) chk(tg, "mem_addr", mem_addr, e_addr);
    chk(tg, "pc", pc_o, m_pc);
    chk(m_s2 ? "R4" : "R1", "nzp", 16'(nzp_o), 16'(m_nzp));
    chk(tg, "rf_we", 16'(rf_we_o), 16'(e_we));
    if (e_we) begin
      chk(tg, "rf_waddr", 16'(rf_waddr_o), 16'(e_wa));
      chk(tg, "rf_wdata", rf_wdata_o, e_wd);
    end
    if (rf_we_o === 1'b1) begin
      seen_w[rf_waddr_o] = rf_wdata_o;
      if (rf_waddr_o == 3'd6) r6_writes++;
    end
    if (m_s2) begin
      case (ph)
        0: begin m_pc = m_pc + 1; ph = 1; end
        1: if (mem_ready) begin m_ir = mem_rdata; ph = 2; end
        2: begin
          ph = 0;
          case (m_ir[15:12])
            4'b0000: if ((m_ir[11:9] & m_nzp) != 3'b000) m_pc = m_pc + sx(m_ir, 9);
            4'b1100: m_pc = m_r[m_ir[8:6]];
            4'b0001, 4'b0101, 4'b1110: ph = 3;
            4'b0110: ph = 4;
            4'b1111: begin m_r[7] = m_pc; ph = 6; end
            default: ;
          endcase
        end
        3: begin e_wd = calc(m_ir, m_pc); m_r[m_ir[11:9]] = e_wd; m_nzp = flags_of(e_wd); ph = 0; end
        4: ph = 5;
        5: if (mem_ready) begin m_r[m_ir[11:9]] = mem_rdata; m_nzp = flags_of(mem_rdata); ph = 0; end
        6: ph = 7;
        7: if (mem_ready) begin m_pc = mem_rdata; ph = 0; end
        default: ph = 0;
      endcase
    end
    m_s2 = m_s1;
    m_s1 = rst_n;
  end

  initial begin
    n_chk = 0; n_bad = 0; r6_writes = 0; finished = 0;
    for (int i = 0; i < 8; i++) seen_w[i] = 16'h0;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    mem[0]  = 16'hE97F; // LEA R4,-129
    mem[1]  = 16'h1265; // ADD R1,R1,#5
    mem[2]  = 16'h147A; // ADD R2,R1,#-6
    mem[3]  = 16'h5681; // AND R3,R2,R1
    mem[4]  = 16'h5A7A; // AND R5,R1,#-6
    mem[5]  = 16'h0803; // BRn +3 (not taken)
    mem[6]  = 16'h0000; // all-zero word
    mem[7]  = 16'h0402; // BRz +2 (taken)
    mem[8]  = 16'h1DA1; // skipped
    mem[9]  = 16'h1DA1; // skipped
    mem[10] = 16'h6C43; // LDR R6,R1,#3
    mem[11] = 16'h613E; // LDR R0,R4,#-2
    mem[12] = 16'hF020; // TRAP 0x20
    mem[13] = 16'h3000; // unused opcode
    mem[14] = 16'h0FFF; // BRnzp -1
    mem[32] = 16'd40;   // trap vector
    mem[40] = 16'h1000; // ADD R0,R0,R0
    mem[41] = 16'hEBFF; // LEA R5,-1
    mem[42] = 16'hC1C0; // JMP R7
    mem[62] = 16'h8000; // data for R0
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
    repeat (RUN_CYCLES) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R3", "final R0", seen_w[0], 16'h0000);
    chk("R3", "final R1", seen_w[1], 16'h0005);
    chk("R3", "final R2", seen_w[2], 16'hFFFF);
    chk("R3", "final R3", seen_w[3], 16'h0005);
    chk("R6", "final R4", seen_w[4], 16'hFF80);
    chk("R6", "final R5", seen_w[5], 16'h0029);
    chk("R8", "final R6", seen_w[6], 16'h1DA1);
    chk("R9", "final R7", seen_w[7], 16'h000D);
    chk("R5", "R6 write count", 16'(r6_writes), 16'd1);
    chk("R10", "pc in final loop", 16'(pc_o == 16'd14 || pc_o == 16'd15), 16'd1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule